// File: doc/BRIEF.md
# Hashed Visited-State Filter with State Queue

This block sits behind a successor-state generator in a state-space explorer. Each cycle it may take one candidate state vector. It hashes the vector with a seed chosen per task, then tests and sets one bit in a visited-bit table at that hash address. A state whose bit was clear is pushed into a first-in first-out state queue, which the generator drains as its work list. A state whose bit was already set is dropped. The filter is lossy by design. Two different states that hash to the same bit count as one. A new state that finds the queue full still leaves its bit set, and is then discarded.

A task begins with a `start` pulse. The pulse latches the seed and a capacity threshold, zeroes all counters and flushes the queue and the pipeline. The bit table is then wiped one word per cycle. Candidates are accepted only after the wipe has finished. The task ends in one of two ways. It ends when the queue and the pipeline have drained after at least one state was enqueued. It also ends when the count of set bits reaches the threshold. A flag reports which of the two ended it. Starting each task with a different seed spreads independent tasks over different parts of the state space.

Top module: `visited_filter`

## Requirements
- R1: After reset, `in_ready`, `clearing`, `task_done`, `done_by_cap` and `q_valid` are low, and all counters read zero.
- R2: A `start` pulse zeroes the counters, empties the queue and raises `clearing` for 2^ADDR_W / WORD_W cycles. Only after that does `in_ready` rise. An `in_valid` state offered while `in_ready` is low has no effect on the queue or the counters.
- R3: The table bit address is the low ADDR_W bits of m ^ (m >> 15). Here m = ((f ^ seed) * 32'h9E3779B1) mod 2^32, and f is the XOR of the 32-bit chunks of the state.
- R4: An accepted state whose bit is clear sets that bit. It then appears at the queue tail, with `enq_count` and `set_count` each one higher, two clock edges after the edge that accepted it.
- R5: An accepted state whose bit is already set is dropped and increments `dup_count`. This includes a different state that hashes to the same address.
- R6: The same state offered on two consecutive cycles is enqueued once and counted once as a duplicate.
- R7: A new state that arrives while the queue holds QUEUE_DEPTH entries is discarded. Its bit is still set, so `full_count` and `set_count` each go up by one.
- R8: The queue returns states in arrival order. `q_pop` removes the head when `q_valid` is high. Fullness is judged on the occupancy before a pop in the same cycle.
- R9: While running, if at least one state has been enqueued, the task ends with `task_done` high and `done_by_cap` low. This happens one edge after a cycle in which the queue is empty, the pipeline is empty and `in_valid` is low.
- R10: While running, if `set_count` ≥ `cap_limit`, `task_done` and `done_by_cap` are both high after the next edge. This check takes priority over the drain check.
- R11: After the task ends, new candidates are refused. States already in the pipeline still complete.
- R12: A later `start` with another seed wipes the table, so states seen in the previous task are accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new task (latch seed and limit, wipe table) |
| seed | input | 32 | Hash seed for the task |
| cap_limit | input | ADDR_W+1 | Set-bit count that ends the task |
| in_valid | input | 1 | Candidate state present |
| in_state | input | STATE_W | Candidate state vector |
| in_ready | output | 1 | Candidates are being accepted |
| q_pop | input | 1 | Remove queue head |
| q_valid | output | 1 | Queue holds at least one state |
| q_state | output | STATE_W | Queue head |
| clearing | output | 1 | Table wipe in progress |
| task_done | output | 1 | Task has ended |
| done_by_cap | output | 1 | Task ended on the capacity threshold |
| enq_count | output | CNT_W | States enqueued this task |
| dup_count | output | CNT_W | States dropped as already visited |
| full_count | output | CNT_W | New states dropped on a full queue |
| set_count | output | ADDR_W+1 | Table bits set this task |

## Verification
The main function is driven with several kinds of input. Fresh distinct states check the enqueue path. A single state offered twice in a row shows whether the forwarding of a pending write works, as opposed to reading stale table contents. The same state offered again after a gap checks the ordinary duplicate path. A pair of different states that the bench finds to share a hash address separates collision dropping from exact-match logic. A long burst with no pops pushes the queue past full and shows that a discarded state still marks the table. The tasks are then restarted with new seeds and low limits. This shows whether the table wipe really happens, and whether the capacity ending is told apart from the drain ending.

// File: rtl/vsf_pkg.sv
// Package: shared types and hash constants for the visited-state filter.
// Assumes: nothing beyond IEEE 1800-2017.
package vsf_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_CLEAR = 2'd1,
        PH_RUN   = 2'd2,
        PH_DONE  = 2'd3
    } phase_e;

    localparam logic [31:0] HASH_MUL   = 32'h9E3779B1;
    localparam int          HASH_SHIFT = 15;

endpackage

// File: rtl/vsf_hash.sv
// Module: vsf_hash
// Folds a state vector to 32 bits by XOR, mixes in the seed, multiplies
// by an odd constant and applies one xor-shift. The low ADDR_W bits give
// the table bit address. It is purely combinational, one pipeline stage
// at the caller. Assumes ADDR_W <= 32.
module vsf_hash
    import vsf_pkg::*;
#(
    parameter int STATE_W = 64,
    parameter int ADDR_W  = 12
) (
    input  logic [STATE_W-1:0] state,
    input  logic [31:0]        seed,
    output logic [ADDR_W-1:0]  addr
);

    localparam int CHUNKS = (STATE_W + 31) / 32;
    localparam int PAD_W  = CHUNKS * 32;

    logic [PAD_W-1:0]       padded;
    logic [CHUNKS:0][31:0]  fold;
    logic [31:0]            prod;
    logic [31:0]            mixed;

    assign padded  = PAD_W'(state);
    assign fold[0] = '0;

    // one XOR stage per 32-bit chunk of the state
    for (genvar g = 0; g < CHUNKS; g++) begin : g_fold
        assign fold[g+1] = fold[g] ^ padded[g*32 +: 32];
    end

    // seed mix, multiply and xor-shift
    assign prod  = (fold[CHUNKS] ^ seed) * HASH_MUL;
    assign mixed = prod ^ (prod >> HASH_SHIFT);
    assign addr  = ADDR_W'(mixed);

endmodule

// File: rtl/vsf_bitmap.sv
// Module: vsf_bitmap
// Visited-bit table kept as words of WORD_W bits. A lookup presented in
// one cycle reads its word. The next cycle reports whether the bit was
// set and writes the word back with that bit set. If the following
// lookup reads the same word, it takes the pending written value. A wipe
// port zeroes one word per cycle. Assumes wipe and lookups never overlap.
module vsf_bitmap #(
    parameter int ADDR_W = 12,
    parameter int WORD_W = 64
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  flush,
    input  logic                                  clr_en,
    input  logic [ADDR_W-$clog2(WORD_W)-1:0]      clr_idx,
    input  logic                                  lk_v,
    input  logic [ADDR_W-1:0]                     lk_addr,
    output logic                                  res_v,
    output logic                                  res_seen
);

    localparam int OFS_W = $clog2(WORD_W);
    localparam int IDX_W = ADDR_W - OFS_W;
    localparam int WORDS = 1 << IDX_W;

    logic [WORD_W-1:0] mem [WORDS];

    logic [IDX_W-1:0]  lk_idx;
    logic [OFS_W-1:0]  lk_ofs;
    logic              s2_v;
    logic [IDX_W-1:0]  s2_idx;
    logic [OFS_W-1:0]  s2_ofs;
    logic [WORD_W-1:0] s2_word;
    logic [WORD_W-1:0] s2_merged;
    logic [WORD_W-1:0] rd_word;

    assign lk_idx    = lk_addr[ADDR_W-1:OFS_W];
    assign lk_ofs    = lk_addr[OFS_W-1:0];
    assign s2_merged = s2_word | (WORD_W'(1) << s2_ofs);

    // read with forwarding of the word being written this cycle
    always_comb begin
        if (s2_v && (s2_idx == lk_idx)) rd_word = s2_merged;
        else                            rd_word = mem[lk_idx];
    end

    // table storage: wipe or write back the merged word
    always_ff @(posedge clk) begin
        if (clr_en)    mem[clr_idx] <= '0;
        else if (s2_v) mem[s2_idx]  <= s2_merged;
    end

    // test stage register
    always_ff @(posedge clk) begin
        if (!rst_n || flush) s2_v <= 1'b0;
        else                 s2_v <= lk_v;
        s2_idx  <= lk_idx;
        s2_ofs  <= lk_ofs;
        s2_word <= rd_word;
    end

    assign res_v    = s2_v;
    assign res_seen = s2_word[s2_ofs];

    // R6: a lookup of the bit being set right now must report it as seen
    a_r6_forward_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_v && s2_v && !flush && (lk_addr == {s2_idx, s2_ofs})) |=> res_seen);

endmodule

// File: rtl/vsf_fifo.sv
// Module: vsf_fifo
// State queue of 2^AW entries with a head output that needs no pop.
// A push while full and a pop while empty are ignored. Flush empties it.
// Assumes the caller gates pushes on full.
module vsf_fifo #(
    parameter int DATA_W = 64,
    parameter int AW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic              empty,
    output logic              full
);

    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [AW:0]       cnt;
    logic              do_push;
    logic              do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == (AW+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    // storage write
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

    // R8: occupancy moves by at most one entry per cycle outside a flush
    a_r8_occupancy_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(flush)) |->
        (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 || cnt == $past(cnt) - 1'b1));

    // R8: the queue never holds more than DEPTH states
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> (cnt <= (AW+1)'(DEPTH)));

endmodule

// File: rtl/visited_filter.sv
// Module: visited_filter (top)
// The block takes one candidate state per cycle. Stage 0 hashes it,
// stage 1 reads the table word and stage 2 tests and sets the bit. From
// stage 2 the state is enqueued, dropped as a duplicate or dropped on a
// full queue. Phase control runs the wipe after start and ends the task
// on drain or on capacity. Assumes `start` is a single-cycle pulse.
module visited_filter
    import vsf_pkg::*;
#(
    parameter int STATE_W  = 64,
    parameter int ADDR_W   = 12,
    parameter int WORD_W   = 64,
    parameter int QUEUE_AW = 4,
    parameter int CNT_W    = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [31:0]        seed,
    input  logic [ADDR_W:0]    cap_limit,
    input  logic               in_valid,
    input  logic [STATE_W-1:0] in_state,
    output logic               in_ready,
    input  logic               q_pop,
    output logic               q_valid,
    output logic [STATE_W-1:0] q_state,
    output logic               clearing,
    output logic               task_done,
    output logic               done_by_cap,
    output logic [CNT_W-1:0]   enq_count,
    output logic [CNT_W-1:0]   dup_count,
    output logic [CNT_W-1:0]   full_count,
    output logic [ADDR_W:0]    set_count
);

    localparam int OFS_W = $clog2(WORD_W);
    localparam int IDX_W = ADDR_W - OFS_W;
    localparam int WORDS = 1 << IDX_W;

    phase_e              phase;
    logic [IDX_W-1:0]    clr_idx;
    logic [31:0]         seed_q;
    logic [ADDR_W:0]     lim_q;
    logic                ever_enq;
    logic                cap_q;

    logic                accept;
    logic [ADDR_W-1:0]   hash_addr;
    logic                s1_v;
    logic [ADDR_W-1:0]   s1_addr;
    logic [STATE_W-1:0]  s1_state;
    logic [STATE_W-1:0]  s2_state;
    logic                res_v;
    logic                res_seen;
    logic                is_new;
    logic                push;
    logic                q_empty;
    logic                q_full;
    logic                drained;

    assign accept  = in_valid && (phase == PH_RUN);
    assign is_new  = res_v && !res_seen;
    assign push    = is_new && !q_full;
    assign drained = ever_enq && q_empty && !s1_v && !res_v && !in_valid;

    vsf_hash #(.STATE_W(STATE_W), .ADDR_W(ADDR_W)) u_hash (
        .state (in_state),
        .seed  (seed_q),
        .addr  (hash_addr)
    );

    // stage 1 register: hashed address and state
    always_ff @(posedge clk) begin
        if (!rst_n || start) s1_v <= 1'b0;
        else                 s1_v <= accept;
        s1_addr  <= hash_addr;
        s1_state <= in_state;
        s2_state <= s1_state;
    end

    vsf_bitmap #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_bitmap (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (start),
        .clr_en   (phase == PH_CLEAR),
        .clr_idx  (clr_idx),
        .lk_v     (s1_v),
        .lk_addr  (s1_addr),
        .res_v    (res_v),
        .res_seen (res_seen)
    );

    vsf_fifo #(.DATA_W(STATE_W), .AW(QUEUE_AW)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (start),
        .push  (push),
        .din   (s2_state),
        .pop   (q_pop),
        .dout  (q_state),
        .empty (q_empty),
        .full  (q_full)
    );

    // phase sequencing: wipe, run, end on capacity or drain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            clr_idx  <= '0;
            seed_q   <= '0;
            lim_q    <= '0;
            ever_enq <= 1'b0;
            cap_q    <= 1'b0;
        end else if (start) begin
            phase    <= PH_CLEAR;
            clr_idx  <= '0;
            seed_q   <= seed;
            lim_q    <= cap_limit;
            ever_enq <= 1'b0;
            cap_q    <= 1'b0;
        end else begin
            if (push) ever_enq <= 1'b1;
            case (phase)
                PH_CLEAR: begin
                    clr_idx <= clr_idx + 1'b1;
                    if (clr_idx == IDX_W'(WORDS - 1)) phase <= PH_RUN;
                end
                PH_RUN: begin
                    if (set_count >= lim_q) begin
                        phase <= PH_DONE;
                        cap_q <= 1'b1;
                    end else if (drained) begin
                        phase <= PH_DONE;
                    end
                end
                default: ;
            endcase
        end
    end

    // outcome counters for the current task
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            enq_count  <= '0;
            dup_count  <= '0;
            full_count <= '0;
            set_count  <= '0;
        end else begin
            if (push)               enq_count  <= enq_count + 1'b1;
            if (res_v && res_seen)  dup_count  <= dup_count + 1'b1;
            if (is_new && q_full)   full_count <= full_count + 1'b1;
            if (is_new)             set_count  <= set_count + 1'b1;
        end
    end

    assign in_ready    = (phase == PH_RUN);
    assign clearing    = (phase == PH_CLEAR);
    assign task_done   = (phase == PH_DONE);
    assign done_by_cap = cap_q;
    assign q_valid     = !q_empty;

    // R10: reaching the threshold while running ends the task on capacity
    a_r10_cap_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RUN && !start && set_count >= lim_q) |=> (task_done && done_by_cap));

    // R11: no new candidate enters the pipeline once the task has ended
    a_r11_no_new_work: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DONE && !start) |=> !s1_v);

    // R2: nothing is accepted during the wipe
    a_r2_wipe_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (clearing && !start) |=> !s1_v);

    // R4: the enqueue counter advances by at most one per cycle
    a_r4_enq_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(start)) |->
        (enq_count == $past(enq_count) || enq_count == $past(enq_count) + 1'b1));

endmodule

// File: tb/test_visited_filter.sv
// Bench: a behavioural reference model is updated on every rising edge
// from the driven inputs. Every output is compared at each falling edge.
module test_visited_filter;

    localparam int STATE_W = 64;
    localparam int ADDR_W  = 12;
    localparam int WORD_W  = 64;
    localparam int QAW     = 4;
    localparam int QDEPTH  = 1 << QAW;
    localparam int NBITS   = 1 << ADDR_W;
    localparam int WORDS   = NBITS / WORD_W;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [31:0]        seed = '0;
    logic [ADDR_W:0]    cap_limit = '0;
    logic               in_valid = 1'b0;
    logic [STATE_W-1:0] in_state = '0;
    logic               q_pop = 1'b0;
    logic               in_ready, q_valid, clearing, task_done, done_by_cap;
    logic [STATE_W-1:0] q_state;
    logic [31:0]        enq_count, dup_count, full_count;
    logic [ADDR_W:0]    set_count;

    always #10 clk = ~clk;

    visited_filter #(.STATE_W(STATE_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W),
                     .QUEUE_AW(QAW), .CNT_W(32)) i_visited_filter (
        .clk(clk), .rst_n(rst_n), .start(start), .seed(seed), .cap_limit(cap_limit),
        .in_valid(in_valid), .in_state(in_state), .in_ready(in_ready),
        .q_pop(q_pop), .q_valid(q_valid), .q_state(q_state),
        .clearing(clearing), .task_done(task_done), .done_by_cap(done_by_cap),
        .enq_count(enq_count), .dup_count(dup_count), .full_count(full_count),
        .set_count(set_count)
    );

    int vectors = 0;
    int miscompares = 0;
    bit armed = 0;

    // reference hash written from R3
    function automatic int ref_hash(input logic [63:0] s, input logic [31:0] sd);
        logic [31:0] f, m;
        f = s[31:0] ^ s[63:32];
        m = (f ^ sd) * 32'h9E3779B1;
        m = m ^ (m >> 15);
        return int'(m & 32'hFFF);
    endfunction

    // reference model state
    int          m_ph = 0;          // 0 idle, 1 wipe, 2 run, 3 done
    int          m_clr = 0;
    bit          m_vis [NBITS];
    logic [63:0] mq [$];
    int          m_enq = 0, m_dup = 0, m_full = 0, m_set = 0;
    bit          m_ever = 0, m_cap = 0;
    logic [31:0] m_seed = '0;
    int          m_lim = 0;
    bit          m_p1v = 0, m_p2v = 0;
    logic [63:0] m_p1s = '0, m_p2s = '0;

    always @(posedge clk) begin
        int  pre_size, pre_set, pre_ph, a;
        bit  do_push;
        armed = 1;
        if (!rst_n) begin
            m_ph = 0; m_clr = 0; mq.delete();
            m_enq = 0; m_dup = 0; m_full = 0; m_set = 0;
            m_ever = 0; m_cap = 0; m_p1v = 0; m_p2v = 0;
        end else if (start) begin
            m_ph = 1; m_clr = 0; mq.delete();
            m_enq = 0; m_dup = 0; m_full = 0; m_set = 0;
            m_ever = 0; m_cap = 0; m_p1v = 0; m_p2v = 0;
            m_seed = seed; m_lim = int'(cap_limit);
            for (int i = 0; i < NBITS; i++) m_vis[i] = 0;
        end else begin
            pre_size = mq.size(); pre_set = m_set; pre_ph = m_ph; do_push = 0;
            if (m_p2v) begin
                a = ref_hash(m_p2s, m_seed);
                if (m_vis[a]) m_dup++;
                else begin
                    m_vis[a] = 1; m_set++;
                    if (pre_size == QDEPTH) m_full++;
                    else do_push = 1;
                end
            end
            if (q_pop && pre_size > 0) void'(mq.pop_front());
            if (do_push) begin mq.push_back(m_p2s); m_enq++; end
            if (pre_ph == 1) begin
                if (m_clr == WORDS - 1) m_ph = 2; else m_clr++;
            end else if (pre_ph == 2) begin
                if (pre_set >= m_lim) begin m_ph = 3; m_cap = 1; end
                else if (m_ever && pre_size == 0 && !m_p1v && !m_p2v && !in_valid) m_ph = 3;
            end
            if (do_push) m_ever = 1;
            m_p2v = m_p1v; m_p2s = m_p1s;
            m_p1v = in_valid && (pre_ph == 2); m_p1s = in_state;
        end
    end

    task automatic chk(input string tag, input string name, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, name, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (armed) begin
            chk("R2", "clearing", longint'(clearing), longint'(m_ph == 1));
            chk("R2", "in_ready", longint'(in_ready), longint'(m_ph == 2));
            chk("R9", "task_done", longint'(task_done), longint'(m_ph == 3));
            chk("R10", "done_by_cap", longint'(done_by_cap), longint'(m_cap));
            chk("R8", "q_valid", longint'(q_valid), longint'(mq.size() > 0));
            if (mq.size() > 0) chk("R8", "q_state", longint'(q_state), longint'(mq[0]));
            chk("R4", "enq_count", longint'(enq_count), longint'(m_enq));
            chk("R5", "dup_count", longint'(dup_count), longint'(m_dup));
            chk("R7", "full_count", longint'(full_count), longint'(m_full));
            chk("R7", "set_count", longint'(set_count), longint'(m_set));
        end
    end

    task automatic cyc(input logic v, input logic [63:0] s, input logic p);
        in_valid = v; in_state = s; q_pop = p;
        @(negedge clk);
    endtask

    task automatic begin_task(input logic [31:0] sd, input int lim, input logic junk);
        start = 1'b1; seed = sd; cap_limit = (ADDR_W+1)'(lim);
        cyc(0, 64'h0, 0);
        start = 1'b0;
        // R2: states offered during the wipe are ignored
        while (!in_ready) cyc(junk, 64'hDEAD_0000_0000_BEEF, 0);
        in_valid = 0;
    endtask

    task automatic drain_all();
        int n = 0;
        while (!task_done && n < 200) begin cyc(0, 64'h0, 1); n++; end
        q_pop = 0;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [63:0] col_a, col_b;
        int first [int];
        bit found;
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc(0, 64'h0, 0);

        // task 1: R4, R6, R5, R7, R9
        begin_task(32'h1234_5678, 4000, 1'b1);
        cyc(1, 64'hA, 0);             // R4 fresh state
        cyc(1, 64'hA, 0);             // R6 back-to-back duplicate
        cyc(1, 64'hB, 0);
        cyc(1, 64'hC, 0);
        cyc(0, 64'h0, 0);
        cyc(1, 64'hA, 0);             // R5 duplicate after a gap
        // R5 collision: two different states with one address under R3
        found = 0; col_a = 0; col_b = 0;
        for (int i = 100; i < 1200 && !found; i++) begin
            int h = ref_hash(64'(i) << 20, 32'h1234_5678);
            if (first.exists(h)) begin
                col_a = 64'(first[h]) << 20; col_b = 64'(i) << 20; found = 1;
            end else first[h] = i;
        end
        cyc(1, col_a, 0);
        cyc(0, 64'h0, 0);
        cyc(1, col_b, 0);
        // R7: burst past full with no pops
        for (int k = 0; k < 24; k++) cyc(1, 64'h5000_0000 + 64'(k) * 64'h1_0001, 0);
        cyc(0, 64'h0, 0);
        cyc(0, 64'h0, 0);
        // R8: a simultaneous pop and push on a full queue
        cyc(1, 64'h7777_0001, 1);
        cyc(1, 64'h7777_0002, 1);
        cyc(0, 64'h0, 0);
        drain_all();                  // R9 drain ending
        // R11: offers after the end are refused
        for (int k = 0; k < 4; k++) cyc(1, 64'h9900 + 64'(k), 0);

        // task 2: R12 new seed, old states accepted again
        begin_task(32'hCAFE_F00D, 4000, 1'b0);
        cyc(1, 64'hA, 0);
        cyc(1, 64'hB, 1);
        cyc(1, 64'hC, 1);
        cyc(1, 64'hA, 1);
        cyc(0, 64'h0, 0);
        drain_all();

        // task 3: R10 capacity ending with in-flight states (R11)
        begin_task(32'h0BAD_1DEA, 5, 1'b0);
        for (int k = 0; k < 10; k++) cyc(1, 64'h3000 + 64'(k) * 64'h101, 0);
        cyc(0, 64'h0, 0);
        repeat (4) cyc(0, 64'h0, 1);

        // task 4: R10 zero limit ends at once
        begin_task(32'h0000_0001, 0, 1'b0);
        repeat (3) cyc(1, 64'h42, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule